// File: doc/BRIEF.md
# Synchronous BCD Stopwatch Core

This block measures elapsed time with a resolution of one hundredth of a second, up to a maximum of 59:59.99. It runs on a single fast system clock. A prescaler turns that clock into a one-cycle tick at 100 Hz. The tick drives a chain of six BCD digits with radices 10, 10, 10, 6, 10 and 6. Every digit sits in the same clock domain, and a digit advances on a cycle when the tick is high and every digit below it holds its terminal value. No digit is clocked by the carry of the digit below.

A level input `run` starts and stops the count, and a synchronous `clear` zeroes the time. The prescaler only counts while `run` is high, so stopping and restarting neither loses nor gains part of a tick. The packed time value can be passed straight to a display decoder. When the count passes its last value, every digit returns to zero and `wrap_pulse` is high for one clock.

The divide ratio is a parameter (30000 for a 3 MHz clock). The number of digits is also a parameter, and the digits follow the repeating radix pattern above. This allows a short chain for quick rollover tests.

Top module: `bcd_stopwatch`

## Requirements
- R1: After reset is released, `time_bcd` is all zero and `wrap_pulse` is low until counting begins.
- R2: While `run` is high and `clear` is low, the hundredths digit advances once every DIV_RATIO clocks. Starting from a cleared state, the first advance is seen after exactly DIV_RATIO running clocks.
- R3: Digits at indices 0, 1, 2 and 4 are mod-10: each wraps from 9 to 0 and carries into the next digit in the same cycle.
- R4: Digits at indices 3 and 5 are mod-6: each wraps from 5 to 0 and carries, so 00:59.99 is followed by 01:00.00.
- R5: Digit i sits in bits [4i+3:4i]: hundredths in [3:0], tenths [7:4], seconds [11:8], tens of seconds [15:12], minutes [19:16], tens of minutes [23:20].
- R6: While `run` is low, `time_bcd` and the prescaler phase hold. After `run` returns high, the next advance comes after the remaining part of the interrupted tick period.
- R7: `clear` zeroes every digit and the prescaler on the next clock edge. It takes priority over `run`, and no `wrap_pulse` follows it.
- R8: When every digit holds its terminal value and a tick arrives, all digits become zero and `wrap_pulse` is high for exactly one clock, in the same cycle in which the zero value first appears.
- R9: No digit ever holds a value at or above its radix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| clear | input | 1 | Synchronous clear of time and prescaler |
| run | input | 1 | Count enable level (high = running) |
| time_bcd | output | 4*NUM_DIGITS | Packed BCD elapsed time, hundredths in the low nibble |
| wrap_pulse | output | 1 | One-clock pulse when the count rolls over to zero |

## Verification
Two directed runs test the carry chain. The first is a short run that separates an off-by-one in the prescaler from a correct DIV_RATIO period. The second is a long run to 00:59.99 and then 01:00.00, which tells whether the mod-6 and mod-10 wrap points are right. A run that is stopped partway through a tick period shows whether the prescaler phase is kept or lost. A clear issued together with `run` checks the priority between the two. Random run/stop bursts with rare clears are then applied to a full chain and to a four-digit chain. The four-digit chain wraps several times, which exposes faults in the wrap pulse and in the carry gating that fixed patterns could miss.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // Radix pattern 10,10,10,6,10,6: odd indices from 3 upward are mod-6.
  function automatic int unsigned digit_radix(input int unsigned idx);
    return ((idx >= 3) && (idx % 2 == 1)) ? 6 : 10;
  endfunction
endpackage

// File: rtl/sw_rst_sync.sv
module sw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
  parameter int unsigned DIV_RATIO = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (run) begin
      if (at_last)    cnt_d = '0;
      else            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & ~clear & at_last;
endmodule

// File: rtl/sw_digit.sv
module sw_digit
  import sw_pkg::*;
#(
  parameter int unsigned RADIX = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output bcd_t value,
  output logic at_last
);
  localparam bcd_t TOP = bcd_t'(RADIX - 1);

  bcd_t val_q, val_d;

  assign at_last = (val_q == TOP);

  always_comb begin
    val_d = val_q;
    if (clear)          val_d = '0;
    else if (advance) begin
      if (at_last)      val_d = '0;
      else              val_d = val_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/bcd_stopwatch.sv
module bcd_stopwatch
  import sw_pkg::*;
#(
  parameter int unsigned DIV_RATIO  = 30000,
  parameter int unsigned NUM_DIGITS = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          run,
  output logic [DIGIT_W*NUM_DIGITS-1:0] time_bcd,
  output logic                          wrap_pulse
);
  localparam int unsigned TIME_W = DIGIT_W * NUM_DIGITS;

  logic                rst_n_int;
  logic                tick;
  logic [NUM_DIGITS:0] step_en;
  logic [NUM_DIGITS-1:0] last;
  logic                wrap_q, wrap_d;

  sw_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sw_prescaler #(.DIV_RATIO(DIV_RATIO)) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clear (clear),
    .run   (run),
    .tick  (tick)
  );

  assign step_en[0] = tick;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    sw_digit #(.RADIX(digit_radix(g))) u_digit (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .clear   (clear),
      .advance (step_en[g]),
      .value   (time_bcd[DIGIT_W*g +: DIGIT_W]),
      .at_last (last[g])
    );
    assign step_en[g+1] = step_en[g] & last[g];
  end

  assign wrap_d = step_en[NUM_DIGITS] & ~clear;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) wrap_q <= 1'b0;
    else            wrap_q <= wrap_d;
  end

  assign wrap_pulse = wrap_q;

  logic unused_w;
  assign unused_w = ^TIME_W;
endmodule

// File: rtl/sw_checker.sv
module sw_checker
  import sw_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          clear,
  input logic                          run,
  input logic [DIGIT_W*NUM_DIGITS-1:0] time_bcd,
  input logic                          wrap_pulse
);
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (time_bcd == '0) && !wrap_pulse);

  assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(time_bcd));

  assert_wrap_is_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (time_bcd == '0));

  assert_wrap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

  assert_wrap_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> $past(run) && !$past(clear));

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_range
    assert_digit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      time_bcd[DIGIT_W*g +: DIGIT_W] < DIGIT_W'(digit_radix(g)));
  end
endmodule

bind bcd_stopwatch sw_checker #(.NUM_DIGITS(NUM_DIGITS)) u_sw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .run        (run),
  .time_bcd   (time_bcd),
  .wrap_pulse (wrap_pulse)
);

// File: tb/test_bcd_stopwatch.sv
module test_bcd_stopwatch;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_M  = 4;
  localparam int DIV_S  = 2;
  localparam int LIM_M  = 360000;
  localparam int LIM_S  = 6000;

  logic        clk, rst_n, clear, run;
  logic [23:0] time_m;
  logic [15:0] time_s;
  logic        wrap_m, wrap_s;

  int n_chk, n_fail;
  int pm, tm, ps, ts;
  bit wm, ws;
  bit finished;

  bcd_stopwatch #(.DIV_RATIO(DIV_M), .NUM_DIGITS(6)) i_bcd_stopwatch (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
    .time_bcd(time_m), .wrap_pulse(wrap_m));

  bcd_stopwatch #(.DIV_RATIO(DIV_S), .NUM_DIGITS(4)) i_bcd_stopwatch_short (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
    .time_bcd(time_s), .wrap_pulse(wrap_s));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] to_bcd(input int t, input int nd);
    logic [23:0] v = '0;
    int rem = t;
    for (int i = 0; i < nd; i++) begin
      int rad = ((i >= 3) && (i % 2 == 1)) ? 6 : 10;
      v[4*i +: 4] = 4'(rem % rad);
      rem = rem / rad;
    end
    return v;
  endfunction

  task automatic model_adv(input bit c, input bit r, input int div, input int lim,
                           ref int p, ref int t, ref bit w);
    w = 1'b0;
    if (c) begin p = 0; t = 0; end
    else if (r) begin
      if (p == div - 1) begin
        p = 0;
        if (t == lim - 1) begin t = 0; w = 1'b1; end
        else t = t + 1;
      end else p = p + 1;
    end
  endtask

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge, model the posedge, compare at the following negedge.
  task automatic step(input bit c, input bit r, input string tag);
    clear = c; run = r;
    @(posedge clk);
    model_adv(c, r, DIV_M, LIM_M, pm, tm, wm);
    model_adv(c, r, DIV_S, LIM_S, ps, ts, ws);
    @(negedge clk);
    check_eq({tag, " main time"},  {8'h0, time_m}, {8'h0, to_bcd(tm, 6)});
    check_eq({tag, " main wrap"},  {31'h0, wrap_m}, {31'h0, wm});
    check_eq({tag, " short time"}, {16'h0, time_s}, {8'h0, to_bcd(ts, 4)});
    check_eq({tag, " short wrap"}, {31'h0, wrap_s}, {31'h0, ws});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int wraps;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clear = 1'b0; run = 1'b0;
    pm = 0; tm = 0; ps = 0; ts = 0; wm = 0; ws = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check_eq("R1 reset time", {8'h0, time_m}, 32'h0);
    check_eq("R1 reset wrap", {31'h0, wrap_m}, 32'h0);
    step(1'b0, 1'b0, "R1");

    // R2: first advance after exactly DIV_RATIO running clocks
    for (int i = 0; i < DIV_M - 1; i++) step(1'b0, 1'b1, "R2");
    check_eq("R2 before period", {8'h0, time_m}, 32'h0);
    step(1'b0, 1'b1, "R2");
    check_eq("R2 one period", {8'h0, time_m}, 32'h1);

    // R6: stop mid-period, hold, resume with remaining phase
    step(1'b0, 1'b1, "R6");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R6");
    check_eq("R6 frozen", {8'h0, time_m}, 32'h1);
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b1, "R6");
    check_eq("R6 phase kept", {8'h0, time_m}, 32'h1);
    step(1'b0, 1'b1, "R6");
    check_eq("R6 resumed", {8'h0, time_m}, 32'h2);

    // R7: clear together with run wins
    step(1'b1, 1'b1, "R7");
    check_eq("R7 clear priority", {8'h0, time_m}, 32'h0);
    check_eq("R7 no wrap", {31'h0, wrap_m}, 32'h0);

    // R3/R5: run to 00:59.99; R4: then 01:00.00. Short chain wraps (R8).
    wraps = 0;
    for (int i = 0; i < 5999 * DIV_M; i++) begin
      step(1'b0, 1'b1, "R3");
      if (wrap_s) wraps++;
    end
    check_eq("R5 field layout 00:59.99", {8'h0, time_m}, 32'h005999);
    for (int i = 0; i < DIV_M; i++) begin
      step(1'b0, 1'b1, "R4");
      if (wrap_s) wraps++;
    end
    check_eq("R4 mod-6 carry 01:00.00", {8'h0, time_m}, 32'h010000);
    check_eq("R8 short chain wrap count", wraps, 32'd2);
    check_eq("R8 short chain zero after wraps", {16'h0, time_s}, 32'h0);

    // Random run/stop bursts with rare clears (R2, R3, R4, R6, R7, R8, R9)
    for (int b = 0; b < 40; b++) begin
      int len = 20 + int'($urandom_range(0, 400));
      bit r = ($urandom_range(0, 3) != 0);
      bit c = ($urandom_range(0, 15) == 0);
      if (c) step(1'b1, r, "R7");
      for (int i = 0; i < len; i++) step(1'b0, r, "R9");
    end
    summary();
  end
endmodule